// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

This block is a memory-mapped general-purpose I/O controller for 96 pins, arranged as three banks of 32. Software reaches it over a plain 32-bit register bus: an address, a write strobe, write data and a combinational read-data return. For every pin it holds a direction bit and an output latch. The output latch can be loaded whole, or changed atomically through separate set and clear registers. Pads, tri-state buffers and pin multiplexing sit outside the block. It exposes a raw input vector, an output vector and an output-enable vector.

Every input passes through a two-flop synchronizer and an optional per-pin inversion. It can then raise an event on a rising edge, a falling edge, a high level or a low level. Each of these four enables is independent per pin. Events latch into a per-bank status register that software clears by writing ones. A read-only register records whether the last edge that set each bit was rising or falling. One interrupt line is high while any status bit of any bank is set.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every register is zero, `pin_out` and `pin_oe` are all zero, `irq` is low, and status reads return zero.
- R2: Byte address = group base + 4 × bank, where bank is `bus_addr[3:2]` and group is `bus_addr[7:4]`. The group bases are: 0x00 direction, 0x10 polarity, 0x20 data, 0x30 set, 0x40 clear, 0x50 rise enable, 0x60 fall enable, 0x70 high enable, 0x80 low enable, 0x90 status, 0xA0 edge. Any of the following is unmapped: bank 3, a group above 0xA, or nonzero `bus_addr[1:0]`. An unmapped address reads zero and ignores writes. Writes to the edge group are ignored.
- R3: Writing the set register ORs the written ones into the output latch; bits written 0 keep their value. Pin i of bank b is vector bit 32·b+i of `pin_out`, `pin_oe` and `pin_in`.
- R4: Writing the clear register clears the output latch where ones are written and leaves other bits alone. A write to the data register loads the latch directly.
- R5: A direction bit of 1 makes the pin an output and drives its `pin_oe` bit. A data read returns the latch for output pins and the synchronized pad value for input pins.
- R6: With the rise enable set, a 0→1 change at `pin_in` sets the pin's status bit on the third rising clock edge after the change. The same event writes 1 into the edge register.
- R7: With the fall enable set, a 1→0 change sets the status bit and writes 0 into the edge register. With both enables set, both directions are detected.
- R8: A high- or low-level enable sets the status bit on every clock while the level persists. A clear and a new event that hit the same bit in the same cycle leave the bit set.
- R9: A polarity bit of 1 inverts the synchronized input before all edge and level detection.
- R10: Writing 1 to a status bit clears it; writing 0 has no effect.
- R11: `irq` is high exactly while any status bit in any bank is set. Status bits of one bank are not affected by pins of another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 96 | Raw pad inputs |
| pin_out | output | 96 | Output latches |
| pin_oe | output | 96 | Output enables (direction bits) |
| irq | output | 1 | Shared interrupt, high while any status bit is set |

## Verification
The bench clears a status bit while a level condition persists. A design that let the clear win would drop an interrupt that is still pending, and the bit would read 0. It writes zeros to status and writes to misaligned, bank-3 and out-of-range addresses. A sloppy decoder would either clear bits or alias those writes onto bank 0. It runs falling edges after rising ones and reads the edge register, which catches a design that records edge direction backwards or only on one edge. It also inverts a pin through polarity while a high-level enable is set. A design that skipped the inversion would report the opposite level.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    // Register group index, taken from bus_addr[7:4]
    typedef enum logic [3:0] {
        GRP_DIR  = 4'h0,
        GRP_POL  = 4'h1,
        GRP_DATA = 4'h2,
        GRP_SET  = 4'h3,
        GRP_CLR  = 4'h4,
        GRP_RISE = 4'h5,
        GRP_FALL = 4'h6,
        GRP_HIGH = 4'h7,
        GRP_LOW  = 4'h8,
        GRP_STAT = 4'h9,
        GRP_EDGE = 4'hA
    } grp_e;

    localparam logic [3:0] GRP_MAX = 4'hA;

    // Address field positions
    localparam int BANK_LSB = 2;
    localparam int GRP_LSB  = 4;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
    import pinbank_pkg::*;
#(
    parameter int PINS        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  grp_e            grp,
    input  logic [PINS-1:0] wr_data,
    input  logic [PINS-1:0] pad_raw,
    output logic [PINS-1:0] rd_val,
    output logic [PINS-1:0] out_q,
    output logic [PINS-1:0] oe_q,
    output logic [PINS-1:0] stat_q
);

    typedef struct packed {
        logic [PINS-1:0] dir;
        logic [PINS-1:0] outl;
        logic [PINS-1:0] pol;
        logic [PINS-1:0] en_rise;
        logic [PINS-1:0] en_fall;
        logic [PINS-1:0] en_high;
        logic [PINS-1:0] en_low;
        logic [PINS-1:0] stat;
        logic [PINS-1:0] edge_up;
        logic [PINS-1:0] prev;
    } bank_state_t;

    bank_state_t st_d, st_q;

    logic [PINS-1:0] pad_sync;
    logic [PINS-1:0] lvl;
    logic [PINS-1:0] ev_rise, ev_fall, ev_high, ev_low, ev_any;
    logic [PINS-1:0] clr_mask;

    pinbank_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_raw),
        .d_out (pad_sync)
    );

    // Event detection on the polarity-adjusted level
    always_comb begin
        lvl     = pad_sync ^ st_q.pol;
        ev_rise = lvl & ~st_q.prev & st_q.en_rise;
        ev_fall = ~lvl & st_q.prev & st_q.en_fall;
        ev_high = lvl & st_q.en_high;
        ev_low  = ~lvl & st_q.en_low;
        ev_any  = ev_rise | ev_fall | ev_high | ev_low;
    end

    // Next-state computation
    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        clr_mask  = '0;

        if (wr_en) begin
            unique case (grp)
                GRP_DIR:  st_d.dir     = wr_data;
                GRP_POL:  st_d.pol     = wr_data;
                GRP_DATA: st_d.outl    = wr_data;
                GRP_SET:  st_d.outl    = st_q.outl | wr_data;
                GRP_CLR:  st_d.outl    = st_q.outl & ~wr_data;
                GRP_RISE: st_d.en_rise = wr_data;
                GRP_FALL: st_d.en_fall = wr_data;
                GRP_HIGH: st_d.en_high = wr_data;
                GRP_LOW:  st_d.en_low  = wr_data;
                GRP_STAT: clr_mask     = wr_data;
                default:  ;
            endcase
        end

        // A new event wins over a same-cycle clear
        st_d.stat    = (st_q.stat & ~clr_mask) | ev_any;
        st_d.edge_up = (st_q.edge_up & ~(ev_rise | ev_fall)) | ev_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read selection for this bank
    always_comb begin
        unique case (grp)
            GRP_DIR:  rd_val = st_q.dir;
            GRP_POL:  rd_val = st_q.pol;
            GRP_DATA: rd_val = (st_q.dir & st_q.outl) | (~st_q.dir & pad_sync);
            GRP_RISE: rd_val = st_q.en_rise;
            GRP_FALL: rd_val = st_q.en_fall;
            GRP_HIGH: rd_val = st_q.en_high;
            GRP_LOW:  rd_val = st_q.en_low;
            GRP_STAT: rd_val = st_q.stat;
            GRP_EDGE: rd_val = st_q.edge_up;
            default:  rd_val = '0;
        endcase
    end

    assign out_q  = st_q.outl;
    assign oe_q   = st_q.dir;
    assign stat_q = st_q.stat;

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NUM_BANKS   = 3,
    parameter int PINS        = 32,
    parameter int SYNC_STAGES = 2,
    localparam int TOTAL      = NUM_BANKS * PINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_we,
    input  logic [PINS-1:0]  bus_wdata,
    output logic [PINS-1:0]  bus_rdata,
    input  logic [TOTAL-1:0] pin_in,
    output logic [TOTAL-1:0] pin_out,
    output logic [TOTAL-1:0] pin_oe,
    output logic             irq
);

    localparam logic [2:0] NB = 3'(NUM_BANKS);

    logic [1:0]      bank_idx;
    logic [3:0]      grp_raw;
    grp_e            grp;
    logic            hit;

    logic [PINS-1:0] rd_val [NUM_BANKS];
    logic [PINS-1:0] stat_b [NUM_BANKS];

    // Address decode
    always_comb begin
        bank_idx = bus_addr[BANK_LSB +: 2];
        grp_raw  = bus_addr[GRP_LSB +: 4];
        grp      = grp_e'(grp_raw);
        hit      = (bus_addr[1:0] == 2'b00) &&
                   (grp_raw <= GRP_MAX) &&
                   ({1'b0, bank_idx} < NB);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pinbank_bank #(
            .PINS        (PINS),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_we && hit && (bank_idx == 2'(b))),
            .grp     (grp),
            .wr_data (bus_wdata),
            .pad_raw (pin_in[b*PINS +: PINS]),
            .rd_val  (rd_val[b]),
            .out_q   (pin_out[b*PINS +: PINS]),
            .oe_q    (pin_oe[b*PINS +: PINS]),
            .stat_q  (stat_b[b])
        );
    end

    // Read return and shared interrupt
    always_comb begin
        bus_rdata = '0;
        irq       = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit && (bank_idx == 2'(b))) begin
                bus_rdata = rd_val[b];
            end
            irq = irq | (|stat_b[b]);
        end
    end

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk #(
    parameter int NUM_BANKS = 3,
    parameter int PINS      = 32,
    localparam int TOTAL    = NUM_BANKS * PINS
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       bus_addr,
    input logic             bus_we,
    input logic [PINS-1:0]  bus_wdata,
    input logic [PINS-1:0]  bus_rdata,
    input logic [TOTAL-1:0] pin_out,
    input logic [TOTAL-1:0] pin_oe,
    input logic             irq
);

    localparam logic [2:0] NB = 3'(NUM_BANKS);

    logic             bank_ok;
    logic             mapped;
    logic [TOTAL-1:0] wmask;
    logic             set_hit, clr_hit, dir_hit, stat_wr;

    always_comb begin
        bank_ok = ({1'b0, bus_addr[3:2]} < NB);
        mapped  = bank_ok && (bus_addr[1:0] == 2'b00) && (bus_addr[7:4] <= 4'hA);
        wmask   = '0;
        if (bank_ok) begin
            wmask[bus_addr[3:2]*PINS +: PINS] = bus_wdata;
        end
        set_hit = bus_we && mapped && (bus_addr[7:4] == 4'h3);
        clr_hit = bus_we && mapped && (bus_addr[7:4] == 4'h4);
        dir_hit = bus_we && mapped && (bus_addr[7:4] == 4'h0);
        stat_wr = bus_we && (bus_addr[7:4] == 4'h9);
    end

    assert_set_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> ((pin_out & $past(wmask)) == $past(wmask)));

    assert_clear_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> ((pin_out & $past(wmask)) == '0));

    assert_oe_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_hit |=> $stable(pin_oe));

    assert_irq_drop_needs_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(stat_wr));

    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == '0));

endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(
    .NUM_BANKS (NUM_BANKS),
    .PINS      (PINS)
) u_chk (.*);

// File: tb/sim_pinbank_ctrl.sv
module sim_pinbank_ctrl;

    localparam int NB = 3;
    localparam int PW = 32;
    localparam int TW = NB * PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [PW-1:0] bus_wdata = '0;
    logic [PW-1:0] bus_rdata;
    logic [TW-1:0] pin_in = '0;
    logic [TW-1:0] pin_out;
    logic [TW-1:0] pin_oe;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    pinbank_ctrl #(.NUM_BANKS(NB), .PINS(PW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    typedef struct packed {
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  raddr;
        logic [31:0] expv;
        logic [3:0]  req;
    } vec_t;

    // Register write/read vectors (requirement number in last field)
    localparam vec_t VECS [15] = '{
        '{8'h00, 32'hF0F0_00FF, 8'h00, 32'hF0F0_00FF, 4'd5},  // R5 direction bank 0
        '{8'h08, 32'hFFFF_FFFF, 8'h08, 32'hFFFF_FFFF, 4'd2},  // R2 bank 2 stride
        '{8'h30, 32'h0000_0011, 8'h20, 32'h0000_0011, 4'd3},  // R3 set
        '{8'h30, 32'h0000_0F00, 8'h20, 32'h0000_0011, 4'd5},  // R5 input bits read pad
        '{8'h40, 32'h0000_0001, 8'h20, 32'h0000_0010, 4'd4},  // R4 clear
        '{8'h38, 32'hA5A5_A5A5, 8'h28, 32'hA5A5_A5A5, 4'd3},  // R3 set bank 2
        '{8'h48, 32'h0000_FFFF, 8'h28, 32'hA5A5_0000, 4'd4},  // R4 clear bank 2
        '{8'h14, 32'h1234_5678, 8'h14, 32'h1234_5678, 4'd9},  // R9 polarity rw
        '{8'h14, 32'h0000_0000, 8'h14, 32'h0000_0000, 4'd9},
        '{8'h54, 32'h0000_0001, 8'h54, 32'h0000_0001, 4'd2},
        '{8'h54, 32'h0000_0000, 8'h54, 32'h0000_0000, 4'd2},
        '{8'h0C, 32'hFFFF_FFFF, 8'h0C, 32'h0000_0000, 4'd2},  // R2 bank 3 unmapped
        '{8'hB0, 32'h0000_0001, 8'hB0, 32'h0000_0000, 4'd2},  // R2 group 0xB unmapped
        '{8'hA0, 32'hFFFF_FFFF, 8'hA0, 32'h0000_0000, 4'd2},  // R2 edge read-only
        '{8'h02, 32'hFFFF_FFFF, 8'h00, 32'hF0F0_00FF, 4'd2}   // R2 misaligned ignored
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rv;

        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        chk("R1 pin_out", pin_out[31:0] | pin_out[63:32] | pin_out[95:64], 32'h0);
        chk("R1 pin_oe", pin_oe[31:0] | pin_oe[63:32] | pin_oe[95:64], 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        bus_read(8'h90, rv); chk("R1 status", rv, 32'h0);
        bus_read(8'h00, rv); chk("R1 dir", rv, 32'h0);

        // Table walk
        foreach (VECS[i]) begin
            bus_write(VECS[i].waddr, VECS[i].wdata);
            bus_read(VECS[i].raddr, rv);
            checks++;
            if (rv !== VECS[i].expv) begin
                errors++;
                $display("FAIL R%0d vector %0d: actual %h expected %h",
                         VECS[i].req, i, rv, VECS[i].expv);
            end
        end

        // Port view after the table
        chk("R3 pin_out bank0", pin_out[31:0], 32'h0000_0F10);
        chk("R4 pin_out bank2", pin_out[95:64], 32'hA5A5_0000);
        chk("R5 pin_oe bank0", pin_oe[31:0], 32'hF0F0_00FF);
        chk("R5 pin_oe bank2", pin_oe[95:64], 32'hFFFF_FFFF);
        chk("R2 bank1 untouched", pin_out[63:32] | pin_oe[63:32], 32'h0);

        // R6 rising edge on bank 1 pin 5
        bus_write(8'h54, 32'h20);
        pin_in[37] = 1'b1;
        wait_cyc(2);
        bus_read(8'h94, rv); chk("R6 not yet set", rv, 32'h0);
        wait_cyc(1);
        bus_read(8'h94, rv); chk("R6 status", rv, 32'h20);
        bus_read(8'hA4, rv); chk("R6 edge up", rv, 32'h20);
        chk("R11 irq set", {31'h0, irq}, 32'h1);
        bus_read(8'h24, rv); chk("R5 input read", rv, 32'h20);

        // R10 write-one-to-clear
        bus_write(8'h94, 32'h0);
        bus_read(8'h94, rv); chk("R10 zero write no effect", rv, 32'h20);
        bus_write(8'h94, 32'h20);
        bus_read(8'h94, rv); chk("R10 cleared", rv, 32'h0);
        chk("R11 irq low", {31'h0, irq}, 32'h0);

        // R7 falling and both edges
        bus_write(8'h64, 32'h20);
        pin_in[37] = 1'b0;
        wait_cyc(3);
        bus_read(8'h94, rv); chk("R7 fall status", rv, 32'h20);
        bus_read(8'hA4, rv); chk("R7 edge down", rv, 32'h0);
        bus_write(8'h94, 32'h20);
        pin_in[37] = 1'b1;
        wait_cyc(3);
        bus_read(8'h94, rv); chk("R7 both rise status", rv, 32'h20);
        bus_read(8'hA4, rv); chk("R7 edge up again", rv, 32'h20);
        bus_write(8'h54, 32'h0);
        bus_write(8'h64, 32'h0);
        bus_write(8'h94, 32'h20);
        bus_read(8'h94, rv); chk("R7 cleared", rv, 32'h0);

        // R8 high level persists over clear
        bus_write(8'h74, 32'h20);
        wait_cyc(2);
        bus_read(8'h94, rv); chk("R8 high level", rv, 32'h20);
        bus_write(8'h94, 32'h20);
        bus_read(8'h94, rv); chk("R8 event beats clear", rv, 32'h20);
        bus_write(8'h74, 32'h0);
        bus_write(8'h94, 32'h20);
        bus_read(8'h94, rv); chk("R8 cleared after disable", rv, 32'h0);
        chk("R8 irq low", {31'h0, irq}, 32'h0);

        // R9 polarity inversion with high-level enable
        bus_write(8'h14, 32'h20);
        bus_write(8'h74, 32'h20);
        wait_cyc(3);
        bus_read(8'h94, rv); chk("R9 inverted high pin no event", rv, 32'h0);
        pin_in[37] = 1'b0;
        wait_cyc(3);
        bus_read(8'h94, rv); chk("R9 inverted low pin event", rv, 32'h20);
        bus_write(8'h74, 32'h0);
        bus_write(8'h14, 32'h0);
        bus_write(8'h94, 32'h20);

        // R8 low level
        bus_write(8'h84, 32'h20);
        wait_cyc(2);
        bus_read(8'h94, rv); chk("R8 low level", rv, 32'h20);
        pin_in[37] = 1'b1;
        wait_cyc(3);
        bus_write(8'h94, 32'h20);
        bus_read(8'h94, rv); chk("R8 level gone clears", rv, 32'h0);
        bus_write(8'h84, 32'h0);

        // R11 another bank drives the shared line
        bus_write(8'h50, 32'h200);
        pin_in[9] = 1'b1;
        wait_cyc(3);
        chk("R11 irq from bank0", {31'h0, irq}, 32'h1);
        bus_read(8'h90, rv); chk("R11 bank0 status", rv, 32'h200);
        bus_read(8'h94, rv); chk("R11 bank1 untouched", rv, 32'h0);
        bus_write(8'h90, 32'h200);
        chk("R11 irq after clear", {31'h0, irq}, 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule